// File: doc/BRIEF.md
# CSR-Mapped UART with Event Unit

This block is a serial port that software reaches through a byte-wide register bus whose registers sit on 32-bit-aligned offsets. One data register serves both directions. A write pushes a byte into a 16-entry transmit queue, and a read returns the byte at the head of a 16-entry receive queue. Two flag registers report whether the transmit queue is full and whether the receive queue is empty. Software polls the first before it writes and the second before it reads.

The serial side sends and receives 8-bit frames. Each frame has one low start bit, eight data bits sent least significant bit first, no parity and one high stop bit. Every bit lasts a fixed number of clock cycles, set by a parameter. An event unit keeps a pending bit for each of two events, gates those bits through an enable register and drives one interrupt line.

A received byte leaves the receive queue only when software acknowledges it. The acknowledge is a write to the pending register with the receive bit set. Reading the data register on its own changes nothing.

Top module: `csr_uart`

## Requirements
- R1: Registers decode on the byte address: data at 0x00, TX-full flag at 0x04, RX-empty flag at 0x08, event status at 0x0C, event pending at 0x10, event enable at 0x14. The flag registers return their flag in bit 0 and zero elsewhere. Any other offset reads 0x00.
- R2: A write to the data register while the TX-full flag is 0 queues the byte. A write while the flag is 1 is dropped. The transmitter holds the line high when idle and sends each queued byte in order as 8N1, least significant bit first, with CLKS_PER_BIT cycles per bit. Up to 16 bytes wait in the queue while one more is being shifted out.
- R3: A read of the data register returns the oldest unacknowledged received byte and does not remove it. Repeated reads return the same byte.
- R4: A write to the pending register with bit 1 set removes one entry from the receive queue. The RX-empty flag and the data register move to the next entry only after that write.
- R5: A pending bit clears when a 1 is written to its position. A 0 leaves it unchanged.
- R6: The RX pending bit (bit 1) is set when a byte enters an empty receive queue, or when an acknowledge leaves entries behind. If a set and a clear hit the same bit in the same cycle, the set wins.
- R7: The TX pending bit (bit 0) is set in the cycle after the transmit queue leaves the full state.
- R8: Event status reads bit 0 = transmit queue not full and bit 1 = receive queue not empty.
- R9: The interrupt output is high exactly when some pending bit and its enable bit are both 1. With enable 0x00 it stays low.
- R10: A byte received while the receive queue holds 16 entries is dropped, and the stored entries are kept in order.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_adr | input | 5 | Register byte address |
| csr_we | input | 1 | Write strobe, one cycle per write |
| csr_wdat | input | 8 | Write data |
| csr_rdat | output | 8 | Read data for csr_adr, combinational |
| irq | output | 1 | Interrupt, OR of pending AND enable |
| uart_txd | output | 1 | Serial transmit line |
| uart_rxd | input | 1 | Serial receive line, asynchronous |

## Verification
The transmitter's move out of the full state can fall in the same cycle as a software write that clears the TX pending bit. To provoke this, the bench fills the transmit queue with TX interrupts enabled. It then writes 0x01 to the pending register on every cycle through the first frame's end, counting the cycles in which the interrupt is high. The set must win over the clear: the interrupt is expected high for exactly one sampled cycle, and the untouched RX pending bit must survive the whole burst. With the transmit line looped back to the receive line, a behavioural model decodes the line, queues the bytes and applies the overflow rule. Every drained byte and flag is judged against that model.

// File: rtl/csr_uart_pkg.sv
// Shared constants and types for the CSR-mapped UART.
// Assumes a 5-bit byte address on the register bus with word-aligned registers.
package csr_uart_pkg;
    localparam int CSR_AW = 5;

    localparam logic [CSR_AW-1:0] OFS_DATA    = 5'h00;
    localparam logic [CSR_AW-1:0] OFS_TXFULL  = 5'h04;
    localparam logic [CSR_AW-1:0] OFS_RXEMPTY = 5'h08;
    localparam logic [CSR_AW-1:0] OFS_EVSTAT  = 5'h0C;
    localparam logic [CSR_AW-1:0] OFS_EVPEND  = 5'h10;
    localparam logic [CSR_AW-1:0] OFS_EVEN    = 5'h14;

    localparam int EV_TX = 0;
    localparam int EV_RX = 1;
    localparam int EV_N  = 2;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;
endpackage

// File: rtl/cu_fifo.sv
// Synchronous FIFO with a combinational head output.
// Assumes DEPTH is a power of two so that the pointers wrap naturally.
// A push while full and a pop while empty are ignored.
module cu_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R10: a push into a full queue without a pop leaves the occupancy unchanged
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));
endmodule

// File: rtl/cu_tx.sv
// 8N1 serial transmitter. It takes a byte whenever it is idle and one is offered.
// Assumes CLKS_PER_BIT >= 2. The line is high while idle.
module cu_tx #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_valid,
    input  logic [7:0] src_data,
    output logic       src_take,
    output logic       txd
);
    localparam int DW = $clog2(CLKS_PER_BIT);

    logic          busy;
    logic [9:0]    shreg;
    logic [DW-1:0] div;
    logic [3:0]    nbits;

    assign src_take = !busy && src_valid;
    assign txd      = busy ? shreg[0] : 1'b1;

    // Frame loading, bit timing and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            shreg <= '1;
            div   <= '0;
            nbits <= '0;
        end else if (!busy) begin
            if (src_valid) begin
                busy  <= 1'b1;
                shreg <= {1'b1, src_data, 1'b0};
                div   <= '0;
                nbits <= '0;
            end
        end else if (div == DW'(CLKS_PER_BIT-1)) begin
            div   <= '0;
            shreg <= {1'b1, shreg[9:1]};
            if (nbits == 4'd9) busy <= 1'b0;
            else               nbits <= nbits + 4'd1;
        end else begin
            div <= div + DW'(1);
        end
    end

    // R2: the start bit appears on the line right after a byte is taken
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_take |=> !txd);
endmodule

// File: rtl/cu_rx.sv
// 8N1 serial receiver. It synchronises the line and samples each bit at its middle.
// It emits a one-cycle pulse with the byte when the stop bit is high.
// Assumes CLKS_PER_BIT >= 2.
module cu_rx #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       out_valid,
    output logic [7:0] out_data
);
    import csr_uart_pkg::*;
    localparam int DW = $clog2(CLKS_PER_BIT);

    logic          sync1, sync2;
    rx_state_t     state;
    logic [DW-1:0] div;
    logic [2:0]    nbit;

    // Two-stage synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= rxd;
            sync2 <= sync1;
        end
    end

    // Frame state machine: start check, data sampling, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            div       <= '0;
            nbit      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            case (state)
                RX_IDLE: begin
                    div <= '0;
                    if (!sync2) state <= RX_START;
                end
                RX_START: begin
                    if (div == DW'(CLKS_PER_BIT/2 - 1)) begin
                        div   <= '0;
                        nbit  <= '0;
                        state <= sync2 ? RX_IDLE : RX_DATA;
                    end else div <= div + DW'(1);
                end
                RX_DATA: begin
                    if (div == DW'(CLKS_PER_BIT-1)) begin
                        div      <= '0;
                        out_data <= {sync2, out_data[7:1]};
                        nbit     <= nbit + 3'd1;
                        if (nbit == 3'd7) state <= RX_STOP;
                    end else div <= div + DW'(1);
                end
                RX_STOP: begin
                    if (div == DW'(CLKS_PER_BIT-1)) begin
                        div       <= '0;
                        out_valid <= sync2;
                        state     <= RX_IDLE;
                    end else div <= div + DW'(1);
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cu_evt.sv
// Event unit: one pending bit per event (set wins over clear-on-write-one), an enable
// register and the interrupt line. Assumes set and clear are single-cycle strobes.
module cu_evt #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic         en_we,
    input  logic [N-1:0] en_wdat,
    output logic [N-1:0] pend,
    output logic [N-1:0] en,
    output logic         irq
);
    // One pending flop per event.
    for (genvar g = 0; g < N; g++) begin : g_pend
        always_ff @(posedge clk) begin
            if (!rst_n) pend[g] <= 1'b0;
            else        pend[g] <= (pend[g] && !clr[g]) || set[g];
        end
    end

    // Enable register, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= '0;
        else if (en_we) en <= en_wdat;
    end

    assign irq = |(pend & en);

    // R9: a cleared enable register keeps the interrupt low
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);

    // R5: with no set and no clear the pending bits hold
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set == '0) && (clr == '0)) |=> $stable(pend));

    // R6: a set strobe always lands, even against a clear
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((pend & $past(set)) == $past(set)));
endmodule

// File: rtl/csr_uart.sv
// CSR-mapped UART top. It decodes the register bus, joins the queues to the serial
// engines and derives the event strobes. Reads have no side effect. A receive entry
// is removed only by writing the pending register with the RX bit set.
// Assumes one bus write per cycle at most and a power-of-two FIFO_DEPTH.
module csr_uart #(
    parameter int CLKS_PER_BIT = 16,
    parameter int FIFO_DEPTH   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] csr_adr,
    input  logic       csr_we,
    input  logic [7:0] csr_wdat,
    output logic [7:0] csr_rdat,
    output logic       irq,
    output logic       uart_txd,
    input  logic       uart_rxd
);
    import csr_uart_pkg::*;
    localparam int CW = $clog2(FIFO_DEPTH+1);

    logic          tx_push, tx_take, tx_empty, tx_full, tx_full_q;
    logic [7:0]    tx_head;
    logic [CW-1:0] tx_cnt;
    logic          rx_valid, rx_pop, rx_empty, rx_full, rx_push_ok, rx_pop_ok;
    logic [7:0]    rx_byte, rx_head;
    logic [CW-1:0] rx_cnt;
    logic          ack_we, en_we;
    logic [EV_N-1:0] ev_set, ev_clr, ev_pend, ev_en;

    assign tx_push = csr_we && (csr_adr == OFS_DATA);
    assign ack_we  = csr_we && (csr_adr == OFS_EVPEND);
    assign en_we   = csr_we && (csr_adr == OFS_EVEN);
    assign rx_pop  = ack_we && csr_wdat[EV_RX];
    assign tx_full = (tx_cnt == CW'(FIFO_DEPTH));
    assign rx_full = (rx_cnt == CW'(FIFO_DEPTH));

    cu_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(csr_wdat),
        .pop(tx_take), .dout(tx_head), .count(tx_cnt), .empty(tx_empty));

    cu_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst_n(rst_n), .src_valid(!tx_empty), .src_data(tx_head),
        .src_take(tx_take), .txd(uart_txd));

    cu_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk(clk), .rst_n(rst_n), .rxd(uart_rxd),
        .out_valid(rx_valid), .out_data(rx_byte));

    cu_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_valid), .din(rx_byte),
        .pop(rx_pop), .dout(rx_head), .count(rx_cnt), .empty(rx_empty));

    // Remembers the previous full state to catch the transmit queue leaving full.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_full_q <= 1'b0;
        else        tx_full_q <= tx_full;
    end

    // Event strobes: TX on leaving full, RX when the queue head becomes valid anew.
    always_comb begin
        rx_push_ok    = rx_valid && !rx_full;
        rx_pop_ok     = rx_pop && !rx_empty;
        ev_set        = '0;
        ev_set[EV_TX] = tx_full_q && !tx_full;
        ev_set[EV_RX] = (rx_push_ok && rx_empty) ||
                        (rx_pop_ok && ((rx_cnt > CW'(1)) || rx_push_ok));
        ev_clr        = ack_we ? csr_wdat[EV_N-1:0] : '0;
    end

    cu_evt #(.N(EV_N)) u_evt (
        .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(ev_clr),
        .en_we(en_we), .en_wdat(csr_wdat[EV_N-1:0]),
        .pend(ev_pend), .en(ev_en), .irq(irq));

    // Register read multiplexer, free of side effects.
    always_comb begin
        csr_rdat = '0;
        case (csr_adr)
            OFS_DATA:    csr_rdat = rx_empty ? 8'h00 : rx_head;
            OFS_TXFULL:  csr_rdat = {7'b0, tx_full};
            OFS_RXEMPTY: csr_rdat = {7'b0, rx_empty};
            OFS_EVSTAT:  csr_rdat = {6'b0, !rx_empty, !tx_full};
            OFS_EVPEND:  csr_rdat = {6'b0, ev_pend};
            OFS_EVEN:    csr_rdat = {6'b0, ev_en};
            default:     csr_rdat = '0;
        endcase
    end

    // R4: without an acknowledge the receive queue never shrinks
    rx_no_ack_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_pop |=> (rx_cnt >= $past(rx_cnt)));

    // R7: leaving the full state raises the TX pending bit one cycle later
    tx_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_full) |=> ev_pend[EV_TX]);
endmodule

// File: tb/csr_uart_test.sv
// Loopback bench: a behavioural line decoder and receive-queue model judge the UART.
module csr_uart_test;
    import csr_uart_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 16;
    localparam int FRAME      = 10*CPB + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] csr_adr = '0;
    logic       csr_we = 1'b0;
    logic [7:0] csr_wdat = '0;
    logic [7:0] csr_rdat;
    logic       irq, uart_txd;

    int checks = 0;
    int errors = 0;
    int line_cnt = 0;
    logic done = 1'b0;
    logic [7:0] sent_q[$];
    logic [7:0] model_rx_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_uart #(.CLKS_PER_BIT(CPB), .FIFO_DEPTH(16)) uut (
        .clk(clk), .rst_n(rst_n), .csr_adr(csr_adr), .csr_we(csr_we),
        .csr_wdat(csr_wdat), .csr_rdat(csr_rdat), .irq(irq),
        .uart_txd(uart_txd), .uart_rxd(uart_txd));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        csr_adr = a; csr_wdat = d; csr_we = 1'b1;
        @(posedge clk);
        #1 csr_we = 1'b0;
    endtask

    task automatic csr_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        csr_adr = a; csr_we = 1'b0;
        #1 d = csr_rdat;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Line decoder: 8N1 frames, LSB first; also models the receive queue with overflow.
    initial begin
        logic [7:0] b;
        forever begin
            @(negedge clk);
            if (rst_n && uart_txd == 1'b0) begin
                repeat (CPB/2) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    repeat (CPB) @(negedge clk);
                    b[i] = uart_txd;
                end
                repeat (CPB) @(negedge clk);
                chk("R2 stop bit", uart_txd, 1);
                line_cnt++;
                if (sent_q.size() == 0) chk("R2 unexpected frame", b, 'h100);
                else chk("R2 frame order", b, sent_q.pop_front());
                // R10: model drops a byte arriving at a full queue
                if (model_rx_q.size() < 16) model_rx_q.push_back(b);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int hi;
        wait_cyc(5);
        @(negedge clk) rst_n = 1'b1;
        wait_cyc(2);

        // Reset state
        chk("R2 idle line", uart_txd, 1);
        chk("R9 irq after reset", irq, 0);
        csr_read(OFS_TXFULL, r);  chk("R1 txfull reset", r, 0);
        csr_read(OFS_RXEMPTY, r); chk("R1 rxempty reset", r, 1);
        csr_read(OFS_EVSTAT, r);  chk("R8 status reset", r, 'h1);
        csr_read(OFS_EVPEND, r);  chk("R5 pending reset", r, 0);
        csr_read(OFS_EVEN, r);    chk("R9 enable reset", r, 0);
        csr_read(5'h18, r);       chk("R1 unmapped offset", r, 0);

        // Three bytes through the loopback
        foreach (sent_q[i]) ;
        sent_q.push_back(8'h3C); sent_q.push_back(8'h81); sent_q.push_back(8'hFF);
        csr_write(OFS_DATA, 8'h3C);
        csr_write(OFS_DATA, 8'h81);
        csr_write(OFS_DATA, 8'hFF);
        wait_cyc(3*FRAME + 60);
        chk("R2 frames seen", line_cnt, 3);
        csr_read(OFS_RXEMPTY, r); chk("R1 rxempty with data", r, 0);
        csr_read(OFS_EVSTAT, r);  chk("R8 status with data", r, 'h3);
        csr_read(OFS_EVPEND, r);  chk("R6 rx pending on arrival", r, 'h2);
        chk("R9 masked irq", irq, 0);
        csr_read(OFS_DATA, r);    chk("R3 head read", r, model_rx_q[0]);
        csr_read(OFS_DATA, r);    chk("R3 repeated read", r, model_rx_q[0]);
        csr_write(OFS_EVPEND, 8'h00);
        csr_read(OFS_EVPEND, r);  chk("R5 zero write keeps", r, 'h2);
        csr_read(OFS_DATA, r);    chk("R4 zero write no pop", r, model_rx_q[0]);
        csr_write(OFS_EVEN, 8'h02);
        @(negedge clk) #1 chk("R9 irq enabled", irq, 1);
        csr_write(OFS_EVEN, 8'h00);
        @(negedge clk) #1 chk("R9 irq masked again", irq, 0);
        for (int k = 0; k < 3; k++) begin
            csr_read(OFS_DATA, r); chk("R4 data in order", r, model_rx_q[0]);
            csr_write(OFS_EVPEND, 8'h02);
            void'(model_rx_q.pop_front());
            csr_read(OFS_RXEMPTY, r); chk("R4 rxempty after ack", r, (model_rx_q.size() == 0) ? 1 : 0);
            csr_read(OFS_EVPEND, r);  chk("R6 rx pending after ack", r, (model_rx_q.size() == 0) ? 0 : 2);
        end
        csr_read(OFS_EVSTAT, r); chk("R8 status drained", r, 'h1);

        // Fill the transmit side: 1 shifting + 16 queued, 18th dropped
        csr_write(OFS_EVEN, 8'h01);
        for (int k = 0; k < 18; k++) begin
            if (k < 17) sent_q.push_back(8'(k*13 + 7));
            csr_write(OFS_DATA, 8'(k*13 + 7));
        end
        csr_read(OFS_TXFULL, r); chk("R2 txfull after 17 writes", r, 1);
        csr_read(OFS_EVSTAT, r); chk("R8 status tx full", r, 'h0);
        // Clear TX pending every cycle across the leave-full moment; set must win once
        hi = 0;
        for (int k = 0; k < 200; k++) begin
            csr_write(OFS_EVPEND, 8'h01);
            if (irq) hi++;
        end
        chk("R6 set wins over clear", hi, 1);
        chk("R7 tx pending seen once", hi, 1);
        csr_read(OFS_EVPEND, r); chk("R5 rx bit kept through tx clears", r, 'h2);
        csr_write(OFS_EVEN, 8'h00);
        wait_cyc(17*FRAME + 100);
        chk("R2 all accepted bytes sent", line_cnt, 20);
        csr_read(OFS_TXFULL, r); chk("R2 txfull cleared", r, 0);
        chk("R10 model holds 16", model_rx_q.size(), 16);
        for (int k = 0; k < 16; k++) begin
            csr_read(OFS_DATA, r); chk("R10 stored order", r, model_rx_q[0]);
            csr_write(OFS_EVPEND, 8'h02);
            void'(model_rx_q.pop_front());
        end
        csr_read(OFS_RXEMPTY, r); chk("R10 overflow byte dropped", r, 1);
        csr_read(OFS_EVPEND, r);  chk("R6 pending after drain", r, 0);
        chk("R9 irq idle", irq, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule